// File: doc/BRIEF.md
# Parallel Dot-Product Neuron Unit

This block is a bit-exact digital model of a unit that evaluates eight neurons at once. Each neuron holds sixteen signed 6-bit synaptic weights and its own 4-bit scale. All neurons share one latched vector of sixteen unsigned 3-bit states. A single evaluate command forms all eight weighted sums in the same cycle. Each sum is shifted left by its neuron's scale and then divided by 64. The quotient is clamped to a 3-bit result, so it saturates at both ends of the range. The eight results are registered together.

Weights enter on a valid/ready stream, two per beat. A beat is accepted only on a cycle where `wt_valid` and `wt_ready` are both high. `wt_ready` drops in any cycle that carries an evaluate command, so a weight update never races a computation. Results leave on a 12-bit valid/ready stream, four results per beat. A read request chooses the lower or upper four neurons. Once `out_valid` is high, the beat stays unchanged until the consumer raises `out_ready`. While the beat is stalled, new read requests are dropped.

Top module: `nu_neuron_array`

## Requirements
- R1: A weight beat is accepted when `wt_valid` and `wt_ready` are both high. Its `wt_data[5:0]` sets synapse 2·`wt_pair` of neuron `wt_neuron`, and `wt_data[11:6]` sets synapse 2·`wt_pair`+1. `wt_ready` is low in every cycle where `calc_cmd` is high, and a beat offered in such a cycle changes no weight.
- R2: Weights are 6-bit two's-complement values. States are unsigned 0..7. `st_load` latches `st_vec`, with synapse j taken from bits [3j+2:3j].
- R3: One `calc_cmd` forms, for every one of the eight neurons at once, the exact sum over sixteen synapses of weight times state.
- R4: `sc_we` writes `sc_val` as the scale of neuron `sc_neuron`. The sum is shifted left by the scale, and any scale above 7 acts as 7.
- R5: The shifted sum is arithmetically shifted right by 6 and clamped to 0..7. Negative values give 0, and values above 7 give 7.
- R6: `res_valid` is high for exactly the one cycle after a cycle with `calc_cmd`. Results are captured at that edge and do not change until the next `calc_cmd`.
- R7: A read request (`out_req`) that is accepted raises `out_valid` on the next cycle. With `out_half`=0 the beat holds neurons 0..3, and with `out_half`=1 it holds neurons 4..7. Neuron 4·half+i sits in bits [3i+2:3i].
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds and `out_req` is ignored. After a handshake with no new request, `out_valid` falls.
- R9: Reset clears all weights, scales, states and results, and drives `res_valid` and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_valid | input | 1 | Weight beat offered |
| wt_ready | output | 1 | Weight beat can be taken |
| wt_neuron | input | 3 | Target neuron of the weight beat |
| wt_pair | input | 3 | Synapse pair index |
| wt_data | input | 12 | Two weights: even synapse low, odd synapse high |
| sc_we | input | 1 | Scale write strobe |
| sc_neuron | input | 3 | Neuron whose scale is written |
| sc_val | input | 4 | Scale value |
| st_load | input | 1 | Latch the state vector |
| st_vec | input | 48 | Sixteen 3-bit states |
| calc_cmd | input | 1 | Evaluate all neurons |
| res_valid | output | 1 | One-cycle pulse after an evaluation |
| out_req | input | 1 | Request a result beat |
| out_half | input | 1 | Which group of four neurons to read |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 12 | Four 3-bit results |

## Verification
Every internal state is visible on the read stream only after an evaluate and one read. A corrupted weight, state or scale therefore shows up two to three cycles after the next `calc_cmd`, as a wrong 3-bit field. The swapped-lane and per-neuron-scale tests make that field name the neuron and the synapse parity at fault. A wrong sign extension or a wrong clamp shows up as 0 turning into 7, or the reverse, in the saturation vectors. A broken stall path shows up as `out_data` changing while `out_ready` is low.

// File: rtl/nu_pkg.sv
package nu_pkg;
  localparam int NU_NEURONS = 8;
  localparam int NU_SYN     = 16;
  localparam int NU_WT_W    = 6;
  localparam int NU_ST_W    = 3;
  localparam int NU_SC_W    = 4;
  localparam int NU_RES_W   = 3;
  localparam int NU_PORT_W  = 12;
  localparam int NU_FRAC    = 6;
  localparam int NU_SH_MAX  = 7;
endpackage

// File: rtl/nu_weight_store.sv
module nu_weight_store #(
  parameter int NEURONS = nu_pkg::NU_NEURONS,
  parameter int SYN     = nu_pkg::NU_SYN,
  parameter int WT_W    = nu_pkg::NU_WT_W,
  localparam int PAIRS  = SYN / 2,
  localparam int NRN_IW = $clog2(NEURONS),
  localparam int PAIR_IW = $clog2(PAIRS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [NRN_IW-1:0]             neuron,
  input  logic [PAIR_IW-1:0]            pair,
  input  logic [2*WT_W-1:0]             data,
  output logic [NEURONS*SYN*WT_W-1:0]   w_flat
);
  // one register slot per synapse pair, each with its own decode
  for (genvar n = 0; n < NEURONS; n++) begin : g_nrn
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic [2*WT_W-1:0] slot_q;
      logic              hit;
      assign hit = we && (neuron == NRN_IW'(n)) && (pair == PAIR_IW'(p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot_q <= '0;
        else if (hit) slot_q <= data;
      end
      assign w_flat[(n*SYN + 2*p)*WT_W +: 2*WT_W] = slot_q;
    end
  end
endmodule

// File: rtl/nu_neuron.sv
module nu_neuron #(
  parameter int SYN    = nu_pkg::NU_SYN,
  parameter int WT_W   = nu_pkg::NU_WT_W,
  parameter int ST_W   = nu_pkg::NU_ST_W,
  parameter int SC_W   = nu_pkg::NU_SC_W,
  parameter int RES_W  = nu_pkg::NU_RES_W,
  parameter int FRAC   = nu_pkg::NU_FRAC,
  parameter int SH_MAX = nu_pkg::NU_SH_MAX,
  localparam int PROD_W = WT_W + ST_W + 1,
  localparam int ACC_W  = PROD_W + $clog2(SYN),
  localparam int SH_W   = ACC_W + SH_MAX,
  localparam int RES_MAX = (1 << RES_W) - 1
) (
  input  logic [SYN*WT_W-1:0] w_vec,
  input  logic [SYN*ST_W-1:0] s_vec,
  input  logic [SC_W-1:0]     scale,
  output logic [RES_W-1:0]    res
);
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic signed [WT_W-1:0]   wj;
  logic signed [ST_W:0]     sj;
  logic [SC_W-1:0]          kc;
  logic signed [SH_W-1:0]   shv;
  logic signed [SH_W-1:0]   q;

  // exact signed dot product; accumulator sized so no term can overflow
  always_comb begin
    acc = '0;
    for (int j = 0; j < SYN; j++) begin
      wj   = $signed(w_vec[j*WT_W +: WT_W]);
      sj   = $signed({1'b0, s_vec[j*ST_W +: ST_W]});
      prod = wj * sj;
      acc  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end
  end

  // clamp the shift count, scale, rescale and saturate
  always_comb begin
    kc  = (scale > SC_W'(SH_MAX)) ? SC_W'(SH_MAX) : scale;
    shv = {{SH_MAX{acc[ACC_W-1]}}, acc} <<< kc;
    q   = shv >>> FRAC;
    if (q[SH_W-1])               res = '0;
    else if (q > SH_W'(RES_MAX)) res = RES_W'(RES_MAX);
    else                         res = q[RES_W-1:0];
  end
endmodule

// File: rtl/nu_out_stage.sv
module nu_out_stage #(
  parameter int NEURONS = nu_pkg::NU_NEURONS,
  parameter int RES_W   = nu_pkg::NU_RES_W,
  parameter int PORT_W  = nu_pkg::NU_PORT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NEURONS*RES_W-1:0]   res_flat,
  input  logic                       req,
  input  logic                       half,
  input  logic                       ready,
  output logic                       valid,
  output logic [PORT_W-1:0]          data
);
  logic              accept;
  logic [PORT_W-1:0] slice;

  assign accept = req && (!valid || ready);
  assign slice  = half ? res_flat[PORT_W +: PORT_W] : res_flat[0 +: PORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (accept) begin
      valid <= 1'b1;
      data  <= slice;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nu_neuron_array.sv
module nu_neuron_array #(
  parameter int NEURONS = nu_pkg::NU_NEURONS,
  parameter int SYN     = nu_pkg::NU_SYN,
  parameter int WT_W    = nu_pkg::NU_WT_W,
  parameter int ST_W    = nu_pkg::NU_ST_W,
  parameter int SC_W    = nu_pkg::NU_SC_W,
  parameter int RES_W   = nu_pkg::NU_RES_W,
  parameter int PORT_W  = nu_pkg::NU_PORT_W,
  parameter int FRAC    = nu_pkg::NU_FRAC,
  parameter int SH_MAX  = nu_pkg::NU_SH_MAX,
  localparam int NRN_IW  = $clog2(NEURONS),
  localparam int PAIR_IW = $clog2(SYN/2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wt_valid,
  output logic                 wt_ready,
  input  logic [NRN_IW-1:0]    wt_neuron,
  input  logic [PAIR_IW-1:0]   wt_pair,
  input  logic [2*WT_W-1:0]    wt_data,
  input  logic                 sc_we,
  input  logic [NRN_IW-1:0]    sc_neuron,
  input  logic [SC_W-1:0]      sc_val,
  input  logic                 st_load,
  input  logic [SYN*ST_W-1:0]  st_vec,
  input  logic                 calc_cmd,
  output logic                 res_valid,
  input  logic                 out_req,
  input  logic                 out_half,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PORT_W-1:0]    out_data
);
  logic [NEURONS*SYN*WT_W-1:0] w_flat;
  logic [SYN*ST_W-1:0]         st_q;
  logic [SC_W-1:0]             sc_q [NEURONS];
  logic [NEURONS*RES_W-1:0]    res_d;
  logic [NEURONS*RES_W-1:0]    res_q;

  assign wt_ready = !calc_cmd;

  nu_weight_store #(.NEURONS(NEURONS), .SYN(SYN), .WT_W(WT_W)) u_wstore (
    .clk(clk), .rst_n(rst_n), .we(wt_valid && wt_ready),
    .neuron(wt_neuron), .pair(wt_pair), .data(wt_data), .w_flat(w_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      for (int i = 0; i < NEURONS; i++) sc_q[i] <= '0;
    end else begin
      if (st_load) st_q <= st_vec;
      if (sc_we)   sc_q[sc_neuron] <= sc_val;
    end
  end

  for (genvar g = 0; g < NEURONS; g++) begin : g_nu
    nu_neuron #(
      .SYN(SYN), .WT_W(WT_W), .ST_W(ST_W), .SC_W(SC_W),
      .RES_W(RES_W), .FRAC(FRAC), .SH_MAX(SH_MAX)
    ) u_nu (
      .w_vec(w_flat[g*SYN*WT_W +: SYN*WT_W]),
      .s_vec(st_q),
      .scale(sc_q[g]),
      .res(res_d[g*RES_W +: RES_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= calc_cmd;
      if (calc_cmd) res_q <= res_d;
    end
  end

  nu_out_stage #(.NEURONS(NEURONS), .RES_W(RES_W), .PORT_W(PORT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .res_flat(res_q), .req(out_req),
    .half(out_half), .ready(out_ready), .valid(out_valid), .data(out_data)
  );
endmodule

// File: rtl/nu_chk.sv
module nu_chk #(
  parameter int RW = 24,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          calc_cmd,
  input logic          res_valid,
  input logic [RW-1:0] res_q,
  input logic          out_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_data
);
  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc_cmd |=> res_valid);
  // R6
  res_only_after_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_cmd |=> !res_valid);
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_cmd |=> $stable(res_q));
  // R7
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && (!out_valid || out_ready)) |=> out_valid);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_req) |=> !out_valid);
endmodule

bind nu_neuron_array nu_chk #(.RW(NEURONS*RES_W), .PW(PORT_W)) u_nu_chk (
  .clk(clk), .rst_n(rst_n), .calc_cmd(calc_cmd), .res_valid(res_valid),
  .res_q(res_q), .out_req(out_req), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_nu_neuron_array.sv
module tb_nu_neuron_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_valid = 0, sc_we = 0, st_load = 0, calc_cmd = 0;
  logic out_req = 0, out_half = 0, out_ready = 1;
  logic [2:0] wt_neuron = 0, wt_pair = 0, sc_neuron = 0;
  logic [11:0] wt_data = 0;
  logic [3:0] sc_val = 0;
  logic [47:0] st_vec = 0;
  logic wt_ready, res_valid, out_valid;
  logic [11:0] out_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nu_neuron_array dut (.*);

  // entry: {weight, state, scale, expected result}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {6'h01, 3'd1, 4'd0,  3'd0},
    {6'h01, 3'd1, 4'd2,  3'd1},
    {6'h02, 3'd3, 4'd1,  3'd3},
    {6'h1F, 3'd7, 4'd0,  3'd7},
    {6'h3F, 3'd4, 4'd5,  3'd0},
    {6'h05, 3'd1, 4'd2,  3'd5},
    {6'h01, 3'd1, 4'd15, 3'd7},
    {6'h01, 3'd1, 4'd4,  3'd4},
    {6'h20, 3'd7, 4'd0,  3'd0},
    {6'h03, 3'd1, 4'd3,  3'd6}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_w(input logic [11:0] d);
    for (int n = 0; n < 8; n++)
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        wt_valid = 1; wt_neuron = 3'(n); wt_pair = 3'(p); wt_data = d;
      end
    @(negedge clk); wt_valid = 0;
  endtask

  task automatic set_sc(input int n, input logic [3:0] k);
    @(negedge clk); sc_we = 1; sc_neuron = 3'(n); sc_val = k;
    @(negedge clk); sc_we = 0;
  endtask

  task automatic set_st(input logic [47:0] v);
    @(negedge clk); st_load = 1; st_vec = v;
    @(negedge clk); st_load = 0;
  endtask

  task automatic calc(input string req);
    @(negedge clk); calc_cmd = 1;
    @(negedge clk); calc_cmd = 0;
    chk(res_valid === 1'b1, req, int'(res_valid), 1);
  endtask

  task automatic rd(input bit h, output logic [11:0] d);
    @(negedge clk); out_req = 1; out_half = h;
    @(negedge clk); out_req = 0;
    chk(out_valid === 1'b1, "R7", int'(out_valid), 1);
    d = out_data;
  endtask

  function automatic logic [47:0] rep_st(input logic [2:0] s);
    logic [47:0] v;
    for (int j = 0; j < 16; j++) v[j*3 +: 3] = s;
    return v;
  endfunction

  initial begin
    #(8*150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] d;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(res_valid === 1'b0, "R9", int'(res_valid), 0);
    chk(out_valid === 1'b0, "R9", int'(out_valid), 0);
    chk(wt_ready === 1'b1, "R1", int'(wt_ready), 1);
    rst_n = 1;
    rd(0, d);
    chk(d === 12'h000, "R9", int'(d), 0);

    // table walk: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [5:0] w; logic [2:0] s, e; logic [3:0] k;
      {w, s, k, e} = VEC[i];
      fill_w({w, w});
      for (int n = 0; n < 8; n++) set_sc(n, k);
      set_st(rep_st(s));
      calc("R6");
      rd(0, d); chk(d === {4{e}}, "R3 R5 low", int'(d), int'({4{e}}));
      rd(1, d); chk(d === {4{e}}, "R4 R5 high", int'(d), int'({4{e}}));
    end

    // R6 res_valid is a single pulse
    @(negedge clk);
    chk(res_valid === 1'b0, "R6", int'(res_valid), 0);

    // R4 R7: scale n on neuron n, w=1 s=1 -> 0,0,1,2,4,7,7,7
    fill_w({6'h01, 6'h01});
    for (int n = 0; n < 8; n++) set_sc(n, 4'(n));
    set_st(rep_st(3'd1));
    calc("R6");
    rd(0, d); chk(d === {3'd2, 3'd1, 3'd0, 3'd0}, "R7 order low", int'(d), 12'o2100);
    rd(1, d); chk(d === {3'd7, 3'd7, 3'd7, 3'd4}, "R7 order high", int'(d), 12'o7774);

    // R6: a state change without calc leaves results alone
    set_st(rep_st(3'd0));
    rd(0, d); chk(d === {3'd2, 3'd1, 3'd0, 3'd0}, "R6 hold", int'(d), 12'o2100);

    // R1 R2: even synapse +31 (low half), odd -32 (high half)
    fill_w({6'h20, 6'h1F});
    for (int n = 0; n < 8; n++) set_sc(n, 4'd0);
    begin
      logic [47:0] v = '0;
      for (int j = 0; j < 16; j += 2) v[j*3 +: 3] = 3'd1;
      set_st(v);
    end
    calc("R6");
    rd(0, d); chk(d === 12'o3333, "R1 lane even", int'(d), 12'o3333);
    begin
      logic [47:0] v = '0;
      for (int j = 1; j < 16; j += 2) v[j*3 +: 3] = 3'd1;
      set_st(v);
    end
    calc("R6");
    rd(1, d); chk(d === 12'o0000, "R2 signed", int'(d), 0);

    // R1: weight beat offered during calc is refused and has no effect
    begin
      logic [47:0] v = '0;
      for (int j = 0; j < 16; j += 2) v[j*3 +: 3] = 3'd1;
      set_st(v);
    end
    @(negedge clk);
    calc_cmd = 1; wt_valid = 1; wt_neuron = 0; wt_pair = 0; wt_data = {6'h20, 6'h20};
    #1 chk(wt_ready === 1'b0, "R1 ready", int'(wt_ready), 0);
    @(negedge clk); calc_cmd = 0; wt_valid = 0;
    calc("R6");
    rd(0, d); chk(d === 12'o3333, "R1 refused", int'(d), 12'o3333);

    // R8 back-pressure
    fill_w({6'h01, 6'h01});
    for (int n = 0; n < 8; n++) set_sc(n, 4'(n));
    set_st(rep_st(3'd1));
    calc("R6");
    @(negedge clk); out_ready = 0; out_req = 1; out_half = 0;
    @(negedge clk); out_half = 1;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1, "R8 valid held", int'(out_valid), 1);
    chk(out_data === 12'o2100, "R8 data held", int'(out_data), 12'o2100);
    out_req = 0; out_ready = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 drop", int'(out_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule